// File: doc/BRIEF.md
# Table-Driven Link-Path Sequencer

This block is a generic state machine engine that contains no transition logic of its own. On each lookup it joins three fields into one table address: a latched process-select field, the synchronised input qualifiers, and the present-state code. The word stored at that address holds two parts. The upper part is the next-state code, which is written back into the state register. The lower part is the set of control outputs, which drive the output port through a register.

The table is given as an elaboration parameter. Any algorithmic state chart can therefore run on the same logic once its transition table has been fully expanded, meaning every don't-care qualifier has been written out as every 0/1 combination. Several such charts share one table, each in the region chosen by the process-select field.

A run can be stopped with a halt input, which freezes the machine. A gap input spaces successive lookups, and a gap of zero gives one lookup per clock. The process-select field is only taken in while halted, so a running machine never reads a mix of two processes' tables.

Top module: `linkpath_seq`

## Requirements
- R1: While `rst_n` is low, `state_o` and `ctl_o` are all zeros and the latched process field is zero.
- R2: Each lookup reads the table word at address {process field, synchronised qualifiers, present state}. The process field is in the most significant bits and the state in the least. The word at address a occupies `TABLE[a*(S_W+O_W) +: S_W+O_W]`.
- R3: On a lookup edge, the upper S_W bits of the word become the new `state_o`, so the next address is built from it.
- R4: On the same lookup edge, the lower O_W bits of the word are registered onto `ctl_o`. Between lookups, `ctl_o` and `state_o` hold their values.
- R5: The qualifiers pass through SYNC_STAGES flops (default two) before joining the address. A value presented during cycle n is first used by the lookup at the edge ending cycle n+SYNC_STAGES.
- R6: `proc_sel` is captured on every edge where `halt` is high and ignored on every edge where `halt` is low.
- R7: On an edge where `halt` is high, no lookup happens, and `state_o` and `ctl_o` keep their values.
- R8: While running, with `gap_cycles` = g sampled at a lookup, the next lookup happens g+1 edges later. With g = 0 there is one lookup per clock.
- R9: The first edge with `halt` low after any halted edge performs a lookup, whatever gap was pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| halt | input | 1 | Stops sequencing; also opens the process-select latch |
| gap_cycles | input | PACE_W | Idle edges inserted after each lookup |
| proc_sel | input | P_W | Table region (process) select |
| qual | input | Q_W | Asynchronous input qualifiers |
| state_o | output | S_W | Present-state code |
| ctl_o | output | O_W | Registered control outputs |

## Verification
The embedded properties check, on every cycle, the following:
- A halted edge freezes the state and outputs.
- The process field cannot move while running.
- Nothing changes on an edge without a lookup.
- A nonzero gap suppresses the following edge.
- Leaving halt produces an immediate lookup.

Only the bench scenarios can show that the right word is fetched. This covers the address order, the split of the word into next state and outputs, the two-edge qualifier latency, and the exact spacing of lookups for each gap value. The bench shows these by comparing the ports each cycle against a reference model that runs on its own table.

// File: rtl/lps_pkg.sv
package lps_pkg;
   // default geometry of the sequencer
   localparam int unsigned DEF_P_W      = 3;
   localparam int unsigned DEF_Q_W      = 2;
   localparam int unsigned DEF_S_W      = 2;
   localparam int unsigned DEF_O_W      = 1;
   localparam int unsigned DEF_PACE_W   = 4;
   localparam int unsigned DEF_SYNC     = 2;

   // number of address bits for a given geometry
   function automatic int unsigned addr_bits(int unsigned pw, int unsigned qw,
                                             int unsigned sw);
      return pw + qw + sw;
   endfunction

   // pacing engine phase
   typedef enum logic [0:0] {
      PH_READY = 1'b0,
      PH_WAIT  = 1'b1
   } pace_phase_e;
endpackage

// File: rtl/lps_sync.sv
module lps_sync #(
   parameter int unsigned W      = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 1) begin : g_single
         logic [W-1:0] ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= '0;
            else        ff <= d;
         end
         assign q = ff;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= '0;
            else begin
               ff[0] <= d;
               for (int i = 1; i < STAGES; i++) ff[i] <= ff[i-1];
            end
         end
         assign q = ff[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/lps_pacer.sv
module lps_pacer
   import lps_pkg::*;
#(
   parameter int unsigned PACE_W = DEF_PACE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              halt,
   input  logic [PACE_W-1:0] gap,
   output logic              step
);
   logic [PACE_W-1:0] wait_cnt;
   pace_phase_e       phase;

   assign phase = (wait_cnt == '0) ? PH_READY : PH_WAIT;
   assign step  = !halt && (phase == PH_READY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      wait_cnt <= '0;
      else if (halt)   wait_cnt <= '0;
      else if (step)   wait_cnt <= gap;
      else             wait_cnt <= wait_cnt - 1'b1;
   end

   AST_GAP_BLOCKS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (step && gap != '0) |=> !step);   // R8
   AST_RESUME_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> (halt || step));   // R9
endmodule

// File: rtl/lps_table.sv
module lps_table #(
   parameter int unsigned AW = 7,
   parameter int unsigned WW = 3,
   parameter logic [(2**AW)*WW-1:0] TABLE = '0
) (
   input  logic [AW-1:0] addr,
   output logic [WW-1:0] word
);
   localparam int unsigned DEPTH = 2**AW;

   logic [DEPTH-1:0][WW-1:0] rows;

   generate
      for (genvar a = 0; a < DEPTH; a++) begin : g_row
         assign rows[a] = TABLE[a*WW +: WW];
      end
   endgenerate

   assign word = rows[addr];
endmodule

// File: rtl/linkpath_seq.sv
module linkpath_seq
   import lps_pkg::*;
#(
   parameter int unsigned P_W         = DEF_P_W,
   parameter int unsigned Q_W         = DEF_Q_W,
   parameter int unsigned S_W         = DEF_S_W,
   parameter int unsigned O_W         = DEF_O_W,
   parameter int unsigned PACE_W      = DEF_PACE_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC,
   parameter logic [(2**(P_W+Q_W+S_W))*(S_W+O_W)-1:0] TABLE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              halt,
   input  logic [PACE_W-1:0] gap_cycles,
   input  logic [P_W-1:0]    proc_sel,
   input  logic [Q_W-1:0]    qual,
   output logic [S_W-1:0]    state_o,
   output logic [O_W-1:0]    ctl_o
);
   localparam int unsigned AW = addr_bits(P_W, Q_W, S_W);
   localparam int unsigned WW = S_W + O_W;

   initial begin : elab_chk
      AST_PARAMS_SANE: assert (P_W >= 1 && Q_W >= 1 && S_W >= 1 && O_W >= 1
                               && PACE_W >= 1 && SYNC_STAGES >= 1 && AW <= 12)
         else $error("linkpath_seq: unsupported geometry");
   end

   logic [Q_W-1:0] qual_s;
   logic [P_W-1:0] proc_q;
   logic [S_W-1:0] state_q;
   logic [O_W-1:0] out_q;
   logic [AW-1:0]  look_addr;
   logic [WW-1:0]  look_word;
   logic           step;

   lps_sync #(.W(Q_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(qual), .q(qual_s));

   lps_pacer #(.PACE_W(PACE_W)) u_pacer (
      .clk(clk), .rst_n(rst_n), .halt(halt), .gap(gap_cycles), .step(step));

   assign look_addr = {proc_q, qual_s, state_q};

   lps_table #(.AW(AW), .WW(WW), .TABLE(TABLE)) u_table (
      .addr(look_addr), .word(look_word));

   // process field opens only while stopped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    proc_q <= '0;
      else if (halt) proc_q <= proc_sel;
   end

   // link part feeds back, instruction part goes out, same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= '0;
         out_q   <= '0;
      end else if (step) begin
         state_q <= look_word[WW-1 -: S_W];
         out_q   <= look_word[O_W-1:0];
      end
   end

   assign state_o = state_q;
   assign ctl_o   = out_q;

   AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> ($stable(state_q) && $stable(out_q)));   // R7
   AST_PROC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !halt |=> $stable(proc_q));   // R6
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> ($stable(out_q) && $stable(state_q)));   // R4
   AST_HALT_NO_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> !step);   // R7
endmodule

// File: tb/linkpath_seq_tb.sv
module linkpath_seq_tb;
   localparam int P_W = 3, Q_W = 2, S_W = 2, O_W = 1, PACE_W = 4;
   localparam int AW = P_W + Q_W + S_W;
   localparam int WW = S_W + O_W;
   localparam int DEPTH = 2**AW;

   function automatic logic [DEPTH*WW-1:0] build_tbl();
      logic [DEPTH*WW-1:0] v;
      v = '0;
      for (int a = 0; a < DEPTH; a++)
         v[a*WW +: WW] = WW'((a*37 + 11) ^ (a >> 2));
      return v;
   endfunction

   localparam logic [DEPTH*WW-1:0] TBL = build_tbl();

   logic clk = 1'b0, rst_n = 1'b0, halt = 1'b1;
   logic [PACE_W-1:0] gap_cycles = '0;
   logic [P_W-1:0] proc_sel = '0;
   logic [Q_W-1:0] qual = '0;
   logic [S_W-1:0] state_o;
   logic [O_W-1:0] ctl_o;

   int n_chk = 0, n_bad = 0;

   // reference model state
   logic [Q_W-1:0] m_s1, m_s2;
   logic [P_W-1:0] m_proc;
   logic [S_W-1:0] m_state;
   logic [O_W-1:0] m_out;
   int             m_gap;

   always #10 clk = ~clk;

   linkpath_seq #(.P_W(P_W), .Q_W(Q_W), .S_W(S_W), .O_W(O_W),
                  .PACE_W(PACE_W), .SYNC_STAGES(2), .TABLE(TBL)) u_dut (
      .clk(clk), .rst_n(rst_n), .halt(halt), .gap_cycles(gap_cycles),
      .proc_sel(proc_sel), .qual(qual), .state_o(state_o), .ctl_o(ctl_o));

   function automatic logic [WW-1:0] tbl_word(int a);
      return TBL[a*WW +: WW];
   endfunction

   task automatic model_reset();
      m_s1 = '0; m_s2 = '0; m_proc = '0; m_state = '0; m_out = '0; m_gap = 0;
   endtask

   task automatic model_edge();
      logic [WW-1:0] w;
      int a;
      if (!halt && m_gap == 0) begin
         a = int'({m_proc, m_s2, m_state});
         w = tbl_word(a);
         m_state = w[WW-1 -: S_W];
         m_out   = w[O_W-1:0];
         m_gap   = int'(gap_cycles);
      end else if (halt) m_gap = 0;
      else m_gap = m_gap - 1;
      if (halt) m_proc = proc_sel;
      m_s2 = m_s1;
      m_s1 = qual;
   endtask

   task automatic compare(string tag);
      n_chk++;
      if (state_o !== m_state || ctl_o !== m_out) begin
         n_bad++;
         $display("FAIL %s: state/out actual %b/%b expected %b/%b at %0t",
                  tag, state_o, ctl_o, m_state, m_out, $time);
      end
   endtask

   task automatic cyc(string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare(tag);
   endtask

   initial begin : watchdog
      #(200000 * 20);
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      int seed;
      logic [31:0] r;
      seed = 32'h5eed;
      r = $urandom(seed);
      model_reset();
      // R1: reset state
      qual = 2'b11; proc_sel = 3'd5; halt = 1'b0; gap_cycles = 4'd0;
      repeat (3) begin
         @(negedge clk);
         compare("R1 reset");
      end
      @(negedge clk);
      rst_n = 1'b1;
      halt = 1'b1; proc_sel = 3'd2;
      repeat (2) cyc("R6 load");
      // R2 R3: gap 0, random qualifiers
      halt = 1'b0;
      for (int i = 0; i < 300; i++) begin
         qual = 2'($urandom);
         cyc("R2 R3 lookup");
      end
      // R5: hold then flip a qualifier
      for (int i = 0; i < 40; i++) begin
         qual = (i % 8 < 4) ? 2'b00 : 2'b11;
         cyc("R5 sync latency");
      end
      // R6: proc_sel ignored while running
      for (int i = 0; i < 100; i++) begin
         proc_sel = 3'($urandom);
         qual = 2'($urandom);
         cyc("R6 ignored running");
      end
      // R7: halted with stimulus moving
      halt = 1'b1;
      for (int i = 0; i < 50; i++) begin
         proc_sel = 3'($urandom);
         qual = 2'($urandom);
         gap_cycles = 4'($urandom);
         cyc("R7 freeze");
      end
      halt = 1'b0;
      // R8 R4: pacing with gaps
      for (int i = 0; i < 400; i++) begin
         gap_cycles = 4'($urandom_range(1, 15));
         qual = 2'($urandom);
         cyc("R8 R4 gap");
      end
      gap_cycles = 4'd15;
      for (int i = 0; i < 40; i++) cyc("R8 max gap");
      // R9: halt during countdown then release
      for (int k = 0; k < 20; k++) begin
         gap_cycles = 4'd9;
         qual = 2'($urandom);
         repeat (3) cyc("R9 pre");
         halt = 1'b1;
         proc_sel = 3'($urandom);
         cyc("R9 halt");
         halt = 1'b0;
         repeat (3) cyc("R9 resume");
      end
      // mixed random
      for (int i = 0; i < 600; i++) begin
         halt = ($urandom_range(0, 4) == 0);
         proc_sel = 3'($urandom);
         gap_cycles = 4'($urandom_range(0, 3));
         qual = 2'($urandom);
         cyc("R2 mixed");
      end
      // R1: reset again mid-run
      rst_n = 1'b0;
      model_reset();
      #1;
      compare("R1 async reset");
      @(negedge clk);
      compare("R1 reset hold");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule